// File: doc/BRIEF.md
# Configuration Sequencing Controller

This block runs the control side of bringing a programmable device from power-up into user operation. After reset it walks a fixed chain of phases: a one-cycle initiation step, a memory-clear phase, a frame-loading phase and a three-step start-up. The memory-clear and frame-loading phases are abstract. Each one waits on an external completion strobe and does no clearing or loading of its own.

When memory clear completes, the block raises its init-ready output. On that rising edge it latches a 3-bit mode code and decodes it into configuration-port attributes:
- clock direction,
- data width,
- serial pass-through output enable,
- whether pull-ups apply before configuration.

It keeps all user outputs in high impedance until start-up releases them. It drives the pull-up and pull-down enables, and it raises the done flag near the end of start-up.

An active-low reprogram input restarts the whole sequence from any phase, including user operation.

Top module: `cfg_sequencer`

## Requirements
- R1: While and right after reset, the outputs take these values:
  - phase = 0 (initiation), with done = 0, init_ready = 0 and io_hiz = 1;
  - pullup_en = 0 and pulldown_en = 0;
  - cclk_dir = 0, data_w8 = 0 and serial_out_en = 0.
- R2: The phase codes are 0 initiation, 1 clear, 2 load, 3 tristate release, 4 done assert and 5 user. Each transition below shows on the outputs one clock after the cycle in which its condition holds:
  - initiation moves to clear one cycle later;
  - clear holds until clear_done = 1, then moves to load;
  - load holds until load_done = 1, then moves to tristate release.
- R3: The attributes are decoded from mode bits [2:1]:
  - 00 gives cclk_dir = 2 (output), data_w8 = 0 and serial_out_en = 1;
  - 01 gives cclk_dir = 1 (input), data_w8 = 1 and serial_out_en = 0;
  - 10 gives cclk_dir = 0 (none), data_w8 = 0 and serial_out_en = 0;
  - 11 gives cclk_dir = 1, data_w8 = 0 and serial_out_en = 1.
- R4: The mode code is sampled only in the cycle that leaves clear. That is the cycle in which init_ready rises. A mode_pins change at any other time leaves the attribute outputs unchanged.
- R5: When the latched mode bit 0 is 0, pullup_en = 1 from the rise of init_ready until io_hiz falls. When that bit is 1, no pull is enabled during that window.
- R6: io_hiz = 1 in phases 0, 1 and 2. It falls on entry to phase 3.
- R7: Start-up runs phase 3, then phase 4, then phase 5, one cycle each. done rises on entry to phase 4 and stays 1 in phase 5.
- R8: If reprog_n = 0 in any cycle, the next outputs are:
  - phase = 0 with done = 0;
  - io_hiz = 1 and init_ready = 0;
  - no pull enabled.

  The block stays in phase 0 while reprog_n stays 0.
- R9: While io_hiz = 0, unused_opt selects the pulls with one cycle of latency:
  - 01 sets pullup_en;
  - 10 sets pulldown_en;
  - 00 and 11 enable neither.
- R10: done = 0 in every phase below 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| reprog_n | input | 1 | Active-low reprogram request |
| mode_pins | input | 3 | Mode code, sampled at the init_ready rise |
| clear_done | input | 1 | Memory-clear completion strobe |
| load_done | input | 1 | Frame-load completion strobe |
| unused_opt | input | 2 | Pull option for unused pins after tristate release |
| phase | output | 3 | Current phase code |
| done | output | 1 | Configuration done flag |
| init_ready | output | 1 | High once memory clear has finished |
| io_hiz | output | 1 | Global tristate for user outputs |
| pullup_en | output | 1 | Pull-up enable |
| pulldown_en | output | 1 | Pull-down enable |
| cclk_dir | output | 2 | Configuration clock direction: 0 none, 1 input, 2 output |
| data_w8 | output | 1 | 1 selects the 8-bit data path, 0 the 1-bit path |
| serial_out_en | output | 1 | Serial pass-through output enable |

## Verification
Directed runs take the sequence through all eight mode codes. A bench model compares the attribute and pull outputs against the decode in every run, which tells the four mode groups and the pull bit apart. A long random run mixes rare reprogram pulses with sparse completion strobes and free-running mode and option inputs. That run separates three cases:
- a mode change inside the sampling cycle from one outside it;
- pulls owed to the mode from pulls owed to the option;
- restarts in early phases from restarts in late phases.

A directed abort during load, with a different mode code afterwards, checks that a restart re-samples the mode.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
    localparam int MODE_W  = 3;
    localparam int OPT_W   = 2;
    localparam int PHASE_W = 3;
    localparam int DIR_W   = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_INIT    = 3'd0,
        PH_CLEAR   = 3'd1,
        PH_LOAD    = 3'd2,
        PH_SU_GTS  = 3'd3,
        PH_SU_DONE = 3'd4,
        PH_USER    = 3'd5
    } phase_e;

    localparam logic [DIR_W-1:0] DIR_NONE = 2'd0;
    localparam logic [DIR_W-1:0] DIR_IN   = 2'd1;
    localparam logic [DIR_W-1:0] DIR_OUT  = 2'd2;

    typedef struct packed {
        logic [DIR_W-1:0] clk_dir;
        logic             w8;
        logic             ser;
        logic             pull;
    } port_attr_t;
endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
    import cfg_seq_pkg::*;
(
    input  logic [MODE_W-1:0] mode_code,
    output port_attr_t        attr
);
    always_comb begin
        attr      = '0;
        attr.pull = ~mode_code[0];
        unique case (mode_code[MODE_W-1:1])
            2'b00: begin attr.clk_dir = DIR_OUT;  attr.w8 = 1'b0; attr.ser = 1'b1; end
            2'b01: begin attr.clk_dir = DIR_IN;   attr.w8 = 1'b1; attr.ser = 1'b0; end
            2'b10: begin attr.clk_dir = DIR_NONE; attr.w8 = 1'b0; attr.ser = 1'b0; end
            default: begin attr.clk_dir = DIR_IN; attr.w8 = 1'b0; attr.ser = 1'b1; end
        endcase
    end

    // R3: the wide path only ever pairs with an input clock
    always_comb begin
        p_wide_needs_input_r3: assert (!attr.w8 || attr.clk_dir == DIR_IN)
            else $error("wide path without input clock");
    end
endmodule

// File: rtl/cfg_pull_ctrl.sv
module cfg_pull_ctrl
    import cfg_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hiz_d,
    input  logic             init_d,
    input  logic             mode_pull_d,
    input  logic [OPT_W-1:0] unused_opt,
    output logic             pullup_q,
    output logic             pulldown_q
);
    typedef struct packed {
        logic up;
        logic down;
    } pull_t;

    pull_t pull_d, pull_q;

    always_comb begin
        pull_d = '0;
        if (!hiz_d) begin
            pull_d.up   = (unused_opt == 2'b01);
            pull_d.down = (unused_opt == 2'b10);
        end else if (init_d && mode_pull_d) begin
            pull_d.up = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pull_q <= '0;
        else        pull_q <= pull_d;
    end

    assign pullup_q   = pull_q.up;
    assign pulldown_q = pull_q.down;

    p_pull_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pull_q.up && pull_q.down));
endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
    import cfg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reprog_n,
    input  logic       clear_done,
    input  logic       load_done,
    input  port_attr_t decoded,
    output phase_e     phase_q,
    output logic       done_q,
    output logic       hiz_q,
    output logic       init_q,
    output port_attr_t attr_q,
    output logic       hiz_d,
    output logic       init_d,
    output logic       mode_pull_d
);
    typedef struct packed {
        phase_e     phase;
        logic       done;
        logic       hiz;
        logic       init;
        port_attr_t attr;
    } seq_t;

    seq_t nx_d, st_q;

    always_comb begin
        nx_d = st_q;
        if (!reprog_n) begin
            nx_d.phase = PH_INIT;
            nx_d.done  = 1'b0;
            nx_d.hiz   = 1'b1;
            nx_d.init  = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_INIT:  nx_d.phase = PH_CLEAR;
                PH_CLEAR: if (clear_done) begin
                    nx_d.phase = PH_LOAD;
                    nx_d.init  = 1'b1;
                    nx_d.attr  = decoded;
                end
                PH_LOAD: if (load_done) begin
                    nx_d.phase = PH_SU_GTS;
                    nx_d.hiz   = 1'b0;
                end
                PH_SU_GTS: begin
                    nx_d.phase = PH_SU_DONE;
                    nx_d.done  = 1'b1;
                end
                PH_SU_DONE: nx_d.phase = PH_USER;
                PH_USER:    nx_d.phase = PH_USER;
                default:    nx_d.phase = PH_INIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_INIT;
            st_q.hiz   <= 1'b1;
        end else begin
            st_q <= nx_d;
        end
    end

    assign phase_q     = st_q.phase;
    assign done_q      = st_q.done;
    assign hiz_q       = st_q.hiz;
    assign init_q      = st_q.init;
    assign attr_q      = st_q.attr;
    assign hiz_d       = nx_d.hiz;
    assign init_d      = nx_d.init;
    assign mode_pull_d = nx_d.attr.pull;

    p_reprog_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reprog_n |=> (st_q.phase == PH_INIT && !st_q.done && st_q.hiz && !st_q.init));
    p_done_late_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.phase == PH_SU_DONE || st_q.phase == PH_USER));
    p_hiz_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_INIT || st_q.phase == PH_CLEAR || st_q.phase == PH_LOAD) |-> st_q.hiz);
    p_clear_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CLEAR && !clear_done && reprog_n) |=> st_q.phase == PH_CLEAR);
    p_startup_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SU_GTS && reprog_n) |=> (st_q.phase == PH_SU_DONE && st_q.done));
    p_attr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(st_q.init) |-> $stable(st_q.attr));
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
    import cfg_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reprog_n,
    input  logic [MODE_W-1:0]   mode_pins,
    input  logic                clear_done,
    input  logic                load_done,
    input  logic [OPT_W-1:0]    unused_opt,
    output logic [PHASE_W-1:0]  phase,
    output logic                done,
    output logic                init_ready,
    output logic                io_hiz,
    output logic                pullup_en,
    output logic                pulldown_en,
    output logic [DIR_W-1:0]    cclk_dir,
    output logic                data_w8,
    output logic                serial_out_en
);
    port_attr_t decoded;
    port_attr_t attr_q;
    phase_e     phase_q;
    logic       hiz_d, init_d, mode_pull_d;

    cfg_mode_decode u_dec (
        .mode_code (mode_pins),
        .attr      (decoded)
    );

    cfg_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .reprog_n    (reprog_n),
        .clear_done  (clear_done),
        .load_done   (load_done),
        .decoded     (decoded),
        .phase_q     (phase_q),
        .done_q      (done),
        .hiz_q       (io_hiz),
        .init_q      (init_ready),
        .attr_q      (attr_q),
        .hiz_d       (hiz_d),
        .init_d      (init_d),
        .mode_pull_d (mode_pull_d)
    );

    cfg_pull_ctrl u_pull (
        .clk         (clk),
        .rst_n       (rst_n),
        .hiz_d       (hiz_d),
        .init_d      (init_d),
        .mode_pull_d (mode_pull_d),
        .unused_opt  (unused_opt),
        .pullup_q    (pullup_en),
        .pulldown_q  (pulldown_en)
    );

    assign phase         = phase_q;
    assign cclk_dir      = attr_q.clk_dir;
    assign data_w8       = attr_q.w8;
    assign serial_out_en = attr_q.ser;

    p_pull_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_hiz && !init_ready) |-> !(pullup_en || pulldown_en));
endmodule

// File: tb/tb_cfg_sequencer.sv
module tb_cfg_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reprog_n = 1'b1;
    logic [2:0] mode_pins = 3'd0;
    logic       clear_done = 1'b0;
    logic       load_done = 1'b0;
    logic [1:0] unused_opt = 2'd0;
    logic [2:0] phase;
    logic       done, init_ready, io_hiz, pullup_en, pulldown_en;
    logic [1:0] cclk_dir;
    logic       data_w8, serial_out_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference state
    logic [2:0] m_ph;
    logic       m_done, m_hiz, m_init, m_pu, m_pd, m_w8, m_ser, m_mpull;
    logic [1:0] m_dir;

    always #4 clk = ~clk;

    cfg_sequencer dut (
        .clk(clk), .rst_n(rst_n), .reprog_n(reprog_n), .mode_pins(mode_pins),
        .clear_done(clear_done), .load_done(load_done), .unused_opt(unused_opt),
        .phase(phase), .done(done), .init_ready(init_ready), .io_hiz(io_hiz),
        .pullup_en(pullup_en), .pulldown_en(pulldown_en), .cclk_dir(cclk_dir),
        .data_w8(data_w8), .serial_out_en(serial_out_en)
    );

    function automatic logic [1:0] dir_of(input logic [2:0] m);
        case (m[2:1])
            2'b00: return 2'd2;
            2'b01: return 2'd1;
            2'b10: return 2'd0;
            default: return 2'd1;
        endcase
    endfunction

    function automatic logic w8_of(input logic [2:0] m);
        return m[2:1] == 2'b01;
    endfunction

    function automatic logic ser_of(input logic [2:0] m);
        return m[2:1] == 2'b00 || m[2:1] == 2'b11;
    endfunction

    task automatic model_reset();
        m_ph = 3'd0; m_done = 0; m_hiz = 1; m_init = 0; m_pu = 0; m_pd = 0;
        m_dir = 2'd0; m_w8 = 0; m_ser = 0; m_mpull = 0;
    endtask

    // advance the reference by one clock edge with the current inputs
    task automatic model_step();
        if (!reprog_n) begin
            m_ph = 3'd0; m_done = 0; m_hiz = 1; m_init = 0;
        end else begin
            case (m_ph)
                3'd0: m_ph = 3'd1;
                3'd1: if (clear_done) begin
                    m_ph = 3'd2; m_init = 1;
                    m_dir = dir_of(mode_pins); m_w8 = w8_of(mode_pins);
                    m_ser = ser_of(mode_pins); m_mpull = ~mode_pins[0];
                end
                3'd2: if (load_done) begin m_ph = 3'd3; m_hiz = 0; end
                3'd3: begin m_ph = 3'd4; m_done = 1; end
                default: m_ph = 3'd5;
            endcase
        end
        if (!m_hiz) begin
            m_pu = (unused_opt == 2'b01);
            m_pd = (unused_opt == 2'b10);
        end else begin
            m_pu = m_init && m_mpull;
            m_pd = 0;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare all outputs with the reference
    task automatic compare_all();
        chk("R2 phase", phase, m_ph);
        chk("R7/R10 done", done, m_done);
        chk("R6 io_hiz", io_hiz, m_hiz);
        chk("R4 init_ready", init_ready, m_init);
        chk("R5/R9 pullup_en", pullup_en, m_pu);
        chk("R9 pulldown_en", pulldown_en, m_pd);
        chk("R3 cclk_dir", cclk_dir, m_dir);
        chk("R3 data_w8", data_w8, m_w8);
        chk("R3 serial_out_en", serial_out_en, m_ser);
    endtask

    // drive inputs at negedge, step reference, check at next negedge
    task automatic cycle(input logic rp, input logic cd, input logic ld,
                         input logic [2:0] md, input logic [1:0] op);
        reprog_n = rp; clear_done = cd; load_done = ld;
        mode_pins = md; unused_opt = op;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 phase", phase, 0);
        chk("R1 done", done, 0);
        chk("R1 io_hiz", io_hiz, 1);
        chk("R1 init_ready", init_ready, 0);
        chk("R1 pulls", {pullup_en, pulldown_en}, 0);
        chk("R1 attrs", {cclk_dir, data_w8, serial_out_en}, 0);
        rst_n = 1'b1;

        // directed full sequence for every mode code
        for (int m = 0; m < 8; m++) begin
            cycle(1'b0, 0, 0, 3'(m), 2'd1);          // R8 restart
            cycle(1'b1, 0, 0, 3'(m), 2'd1);          // R2 init -> clear
            cycle(1'b1, 0, 0, 3'(~m), 2'd1);         // R4 ignored change
            cycle(1'b1, 1, 0, 3'(m), 2'd1);          // R4 sample
            cycle(1'b1, 0, 0, 3'(~m), 2'd2);         // R5 pulls from mode
            cycle(1'b1, 0, 1, 3'(~m), 2'(m));        // R6 release
            cycle(1'b1, 0, 0, 3'(~m), 2'(m));        // R7 done
            cycle(1'b1, 0, 0, 3'(m), 2'(m + 1));     // R7 user, R9
            cycle(1'b1, 0, 0, 3'(m), 2'(m + 2));     // R9
        end

        // R8 abort during load, then resample with another mode
        cycle(1'b0, 0, 0, 3'd1, 2'd0);
        cycle(1'b1, 0, 0, 3'd1, 2'd0);
        cycle(1'b1, 1, 0, 3'd2, 2'd0);
        cycle(1'b0, 0, 1, 3'd2, 2'd0);
        cycle(1'b1, 0, 0, 3'd5, 2'd0);
        cycle(1'b1, 1, 0, 3'd6, 2'd0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic rp, cd, ld;
            rp = ($urandom_range(99) >= 3);
            cd = ($urandom_range(99) < 30);
            ld = ($urandom_range(99) < 30);
            cycle(rp, cd, ld, 3'($urandom_range(7)), 2'($urandom_range(3)));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule